// File: doc/BRIEF.md
# Edge Capture Unit with Rising and Falling Latches

This block samples a single input that shares its pin with a PWM output channel and records the value of a running down-counter when that input changes level. A low-to-high change stores the counter in a rise latch. A high-to-low change stores it in a separate fall latch. Each of the two events raises its own sticky flag. Software clears a flag by writing a one to the matching bit of a clear strobe. Each flag has an interrupt enable, and the interrupt line is driven from the enabled flags.

The pin is brought in through a synchroniser with a configurable number of stages. A small state machine then follows the synchronised level. Its states are `ST_OFF`, where capture is inactive, `ST_WAIT_RISE`, where the last level seen is low, and `ST_WAIT_FALL`, where the last level seen is high. The transitions are as follows:
- `OFF→WAIT_RISE` and `OFF→WAIT_FALL` happen on activation and follow the current level.
- `WAIT_RISE→WAIT_FALL` is the rising event.
- `WAIT_FALL→WAIT_RISE` is the falling event.
- Either waiting state goes back to `OFF` on deactivation.

Capture is active only while the channel's capture enable is high and its PWM output drive is off, because the two uses of the pin exclude each other. Software is expected to service a flag before the pin changes again, so the shortest usable spacing between edges is the service latency.

Top module: `pwm_pin_capture`

## Requirements
- R1: After reset, both latches are zero and both flags and `irq` are low.
- R2: A low-to-high pin change while capture is active and `rise_en`=1 makes `rise_latch` take the `counter` value present at the third rising clock edge after the change, and sets `rise_flag` at that same edge. Neither output has changed after only two edges.
- R3: A high-to-low pin change while active and `fall_en`=1 loads `fall_latch` and sets `fall_flag` with the same timing. `rise_latch` and `rise_flag` are not affected.
- R4: With `rise_en`=0 a rising change neither loads `rise_latch` nor sets `rise_flag`. With `fall_en`=0 the same holds for falling changes and `fall_latch` and `fall_flag`.
- R5: While `cap_en`=0 or `pwm_oe`=1, pin changes alter no latch or flag. Activating capture while the pin is already high produces no rising event, and the next falling change is still captured.
- R6: `flag_clr` bit 0 clears `rise_flag` and bit 1 clears `fall_flag` at the next clock edge. A zero bit leaves its flag unchanged.
- R7: If a clear bit and a new event for the same flag land on the same clock edge, the flag stays set.
- R8: `irq` = (`rise_flag` & `rise_ie`) | (`fall_flag` & `fall_ie`) at all times.
- R9: A new enabled event overwrites its latch even when its flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_pin | input | 1 | Shared pin level, asynchronous |
| counter | input | CNT_W | Running down-counter value |
| cap_en | input | 1 | Capture function enable for the channel |
| pwm_oe | input | 1 | PWM drives the pin; blocks capture |
| rise_en | input | 1 | Rising-edge capture enable |
| fall_en | input | 1 | Falling-edge capture enable |
| rise_ie | input | 1 | Rising flag interrupt enable |
| fall_ie | input | 1 | Falling flag interrupt enable |
| flag_clr | input | 2 | Write-one-to-clear strobe; bit 0 rise, bit 1 fall |
| rise_latch | output | CNT_W | Counter value at last rising capture |
| fall_latch | output | CNT_W | Counter value at last falling capture |
| rise_flag | output | 1 | Rising capture flag |
| fall_flag | output | 1 | Falling capture flag |
| irq | output | 1 | Capture interrupt |

## Verification
The bench builds the block with `CNT_W`=8 and the default two-stage synchroniser. This makes it practical to sweep every counter value through both latches, with the rise and fall values mirrored so that a swapped or truncated bit shows up. It also steps through all sixteen combinations of the two edge enables and two interrupt enables. The short counter keeps each sweep to a few thousand cycles. The configuration still exposes the three-edge capture latency and the same-edge clear-versus-set case.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_WAIT_RISE = 2'd1,
        ST_WAIT_FALL = 2'd2
    } cap_state_e;

    localparam int SLOT_RISE = 0;
    localparam int SLOT_FALL = 1;
    localparam int NUM_SLOTS = 2;

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cap_edge_fsm.sv
module cap_edge_fsm
    import cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic active,
    output logic evt_rise,
    output logic evt_fall
);
    cap_state_e state, state_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_OFF: begin
                if (active) state_n = level ? ST_WAIT_FALL : ST_WAIT_RISE;
            end
            ST_WAIT_RISE: begin
                if (!active)    state_n = ST_OFF;
                else if (level) state_n = ST_WAIT_FALL;
            end
            ST_WAIT_FALL: begin
                if (!active)     state_n = ST_OFF;
                else if (!level) state_n = ST_WAIT_RISE;
            end
            default: state_n = ST_OFF;
        endcase
    end

    // Output logic: event pulses on the transitions between waiting states
    always_comb begin
        evt_rise = 1'b0;
        evt_fall = 1'b0;
        unique case (state)
            ST_OFF:       ;
            ST_WAIT_RISE: evt_rise = active & level;
            ST_WAIT_FALL: evt_fall = active & ~level;
            default:      ;
        endcase
    end
endmodule

// File: rtl/cap_slot.sv
module cap_slot #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             en,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] value,
    output logic             flag,
    output logic             set
);
    assign set = evt & en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
            flag  <= 1'b0;
        end else begin
            if (set) value <= cnt;
            flag <= (flag & ~clr) | set;
        end
    end
endmodule

// File: rtl/pwm_pin_capture.sv
module pwm_pin_capture
    import cap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic [CNT_W-1:0] counter,
    input  logic             cap_en,
    input  logic             pwm_oe,
    input  logic             rise_en,
    input  logic             fall_en,
    input  logic             rise_ie,
    input  logic             fall_ie,
    input  logic [1:0]       flag_clr,
    output logic [CNT_W-1:0] rise_latch,
    output logic [CNT_W-1:0] fall_latch,
    output logic             rise_flag,
    output logic             fall_flag,
    output logic             irq
);
    logic pin_sync;
    logic active;
    logic [NUM_SLOTS-1:0] slot_evt, slot_en, slot_ie, slot_flag, slot_set;
    logic [CNT_W-1:0]     slot_val [NUM_SLOTS];

    assign active = cap_en & ~pwm_oe;

    cap_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(cap_pin), .q(pin_sync)
    );

    cap_edge_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .level(pin_sync), .active(active),
        .evt_rise(slot_evt[SLOT_RISE]), .evt_fall(slot_evt[SLOT_FALL])
    );

    assign slot_en[SLOT_RISE] = rise_en;
    assign slot_en[SLOT_FALL] = fall_en;
    assign slot_ie[SLOT_RISE] = rise_ie;
    assign slot_ie[SLOT_FALL] = fall_ie;

    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
            cap_slot #(.CNT_W(CNT_W)) i_slot (
                .clk(clk), .rst_n(rst_n), .evt(slot_evt[i]), .en(slot_en[i]),
                .clr(flag_clr[i]), .cnt(counter), .value(slot_val[i]),
                .flag(slot_flag[i]), .set(slot_set[i])
            );
        end
    endgenerate

    assign rise_latch = slot_val[SLOT_RISE];
    assign fall_latch = slot_val[SLOT_FALL];
    assign rise_flag  = slot_flag[SLOT_RISE];
    assign fall_flag  = slot_flag[SLOT_FALL];
    assign irq        = |(slot_flag & slot_ie);
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_en,
    input logic             pwm_oe,
    input logic             rise_en,
    input logic             fall_en,
    input logic [1:0]       flag_clr,
    input logic [1:0]       slot_set,
    input logic [CNT_W-1:0] rise_latch,
    input logic [CNT_W-1:0] fall_latch,
    input logic             rise_flag,
    input logic             fall_flag,
    input logic             irq
);
    // R2
    rise_load_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rise_latch) |-> rise_flag);

    // R3
    fall_load_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fall_latch) |-> fall_flag);

    // R4
    rise_disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_en |=> $stable(rise_latch));

    // R4
    fall_disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_en |=> $stable(fall_latch));

    // R5
    inactive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en || pwm_oe) |=> ($stable(rise_latch) && $stable(fall_latch)));

    // R6
    rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr[0] && !slot_set[0]) |=> !rise_flag);

    // R7
    rise_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_set[0] |=> rise_flag);

    // R7
    fall_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_set[1] |=> fall_flag);

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rise_flag || fall_flag));
endmodule

bind pwm_pin_capture cap_checker #(.CNT_W(CNT_W)) i_cap_checker (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .pwm_oe(pwm_oe),
    .rise_en(rise_en), .fall_en(fall_en), .flag_clr(flag_clr),
    .slot_set(slot_set), .rise_latch(rise_latch), .fall_latch(fall_latch),
    .rise_flag(rise_flag), .fall_flag(fall_flag), .irq(irq)
);

// File: tb/test_pwm_pin_capture.sv
module test_pwm_pin_capture;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_pin = 1'b0;
    logic [CNT_W-1:0] counter = '0;
    logic cap_en = 1'b0, pwm_oe = 1'b0;
    logic rise_en = 1'b0, fall_en = 1'b0, rise_ie = 1'b0, fall_ie = 1'b0;
    logic [1:0] flag_clr = 2'b00;
    logic [CNT_W-1:0] rise_latch, fall_latch;
    logic rise_flag, fall_flag, irq;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model
    int m_rl = 0, m_fl = 0;
    bit m_rf = 0, m_ff = 0;
    bit prev_pin = 0;

    always #2 clk = ~clk;

    pwm_pin_capture #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_pwm_pin_capture (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .counter(counter),
        .cap_en(cap_en), .pwm_oe(pwm_oe), .rise_en(rise_en), .fall_en(fall_en),
        .rise_ie(rise_ie), .fall_ie(fall_ie), .flag_clr(flag_clr),
        .rise_latch(rise_latch), .fall_latch(fall_latch),
        .rise_flag(rise_flag), .fall_flag(fall_flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " rise_latch"}, int'(rise_latch), m_rl);
        chk({req, " fall_latch"}, int'(fall_latch), m_fl);
        chk({req, " rise_flag"}, int'(rise_flag), int'(m_rf));
        chk({req, " fall_flag"}, int'(fall_flag), int'(m_ff));
        // R8: interrupt from enabled flags
        chk({req, " R8 irq"}, int'(irq), int'((m_rf & rise_ie) | (m_ff & fall_ie)));
    endtask

    // Drive a pin level with a counter value, wait three edges, sample at negedge
    task automatic do_edge(input bit lvl, input int val);
        bit act;
        @(negedge clk);
        counter = val[CNT_W-1:0];
        cap_pin = lvl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        act = cap_en && !pwm_oe;
        if (act && lvl && !prev_pin && rise_en) begin m_rl = val; m_rf = 1; end
        if (act && !lvl && prev_pin && fall_en) begin m_fl = val; m_ff = 1; end
        prev_pin = lvl;
    endtask

    task automatic do_clear(input logic [1:0] bits);
        @(negedge clk);
        flag_clr = bits;
        @(negedge clk);
        flag_clr = 2'b00;
        if (bits[0]) m_rf = 0;
        if (bits[1]) m_ff = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        rise_ie = 1; fall_ie = 1;
        chk_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1");

        cap_en = 1; rise_en = 1; fall_en = 1;
        repeat (4) @(negedge clk);

        // R2: latency - nothing after two edges, captured after the third
        @(negedge clk);
        counter = 8'hA5; cap_pin = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R2 early flag", int'(rise_flag), 0);
        chk("R2 early latch", int'(rise_latch), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R2 rise_latch", int'(rise_latch), 8'hA5);
        chk("R2 rise_flag", int'(rise_flag), 1);
        m_rl = 8'hA5; m_rf = 1; prev_pin = 1;
        do_edge(0, 8'h3C);
        chk_all("R3");
        do_clear(2'b11);
        chk_all("R6");

        // R2 R3: sweep every counter value through both latches
        for (int v = 0; v < (1 << CNT_W); v++) begin
            do_edge(1, v);
            chk_all("R2 sweep");
            do_edge(0, (1 << CNT_W) - 1 - v);
            chk_all("R3 sweep");
            do_clear(2'b11);
        end

        // R4 R8: all enable combinations
        for (int c = 0; c < 16; c++) begin
            rise_en = c[0]; fall_en = c[1]; rise_ie = c[2]; fall_ie = c[3];
            do_edge(1, 3 * c + 1);
            chk_all("R4 cfg rise");
            do_edge(0, 5 * c + 2);
            chk_all("R4 cfg fall");
            do_clear(2'b11);
            chk_all("R6 cfg clear");
        end
        rise_en = 1; fall_en = 1; rise_ie = 1; fall_ie = 1;

        // R6: clear one flag only
        do_edge(1, 11);
        do_edge(0, 22);
        do_clear(2'b01);
        chk_all("R6 bit0 only");
        do_edge(1, 33);
        do_clear(2'b10);
        chk_all("R6 bit1 only");
        do_clear(2'b00);
        chk_all("R6 zero bits");

        // R9: overwrite while flag set
        do_edge(0, 44);
        do_edge(1, 55);
        chk_all("R9 rise overwrite");
        do_edge(0, 66);
        chk_all("R9 fall overwrite");

        // R7: clear on the same edge as a new rising event
        @(negedge clk);
        counter = 8'd77; cap_pin = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        flag_clr = 2'b01;
        @(posedge clk);
        @(negedge clk);
        flag_clr = 2'b00;
        m_rl = 77; m_rf = 1; prev_pin = 1;
        chk_all("R7 same edge");
        chk("R7 rise_flag", int'(rise_flag), 1);
        do_clear(2'b11);

        // R5: capture disabled, then PWM output mode
        cap_en = 0;
        do_edge(0, 88);
        do_edge(1, 99);
        chk_all("R5 cap_en low");
        cap_en = 1; pwm_oe = 1;
        repeat (3) @(negedge clk);
        do_edge(0, 101);
        do_edge(1, 102);
        chk_all("R5 pwm_oe high");
        // R5: activation while pin high gives no rising event
        pwm_oe = 0;
        repeat (5) @(negedge clk);
        chk_all("R5 enable while high");
        do_edge(0, 103);
        chk_all("R5 fall after enable");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule